// File: doc/BRIEF.md
# Serial word aligner

This block turns the bit pairs recovered from a few serial lanes into 10-bit symbols. Each fast clock a double-edge sampler hands it two bits per lane; five fast clocks make one pixel clock. A small gearbox packs those five pairs into a 10-bit word. It keeps the two most recent words as a 20-bit history, and a per-lane offset chooses which ten contiguous bits of that history leave as the lane's symbol. All lanes are presented side by side as one wide word, together with a one-cycle valid pulse per pixel clock.

Nothing in the stream marks where a symbol starts. For that reason every lane has a counter of control tokens. Software starts a measurement window of a chosen number of pixel clocks. Over that window each lane counts how many of its symbols are control tokens at the lane's current offset. When the window closes a done flag rises. Software repeats this for every offset and keeps, for each lane, the offset with the highest count.

Top module: `serial_word_aligner`

## Requirements
- R1: Each fast clock delivers two bits per lane on `pair_i`. Bit 0 of the pair is the earlier one in the stream. A lane's stream is taken in cycle order with the earliest bit in symbol bit 0. A pixel boundary falls on the fifth fast cycle after reset and on every fifth cycle after that. Each boundary packs the five pairs that end with that cycle into one word.
- R2: Each lane keeps a 20-bit history of its two most recent words, with the older word in bits 9:0.
- R3: The symbol of a lane is history bits [k+9:k], where k is the lane's latched offset. An offset field value above 9 acts as 9.
- R4: Lane c's symbol appears on `word_o[10c+9:10c]`. `word_valid_o` is high for exactly the one fast cycle that follows each pixel boundary. `word_o` changes only in that cycle.
- R5: An offset is sampled only on a pixel-boundary cycle. It applies from the symbol produced right after that boundary.
- R6: A lane's count rises by one for each counted symbol equal to 0x354, 0x0AB, 0x154 or 0x2AB.
- R7: A start pulse clears every count and the done flag. The next max(L,1) symbols are then counted, where L is `scan_len_i`. After the last of them `scan_done_o` rises and stays high until the next start. Counts hold after the window.
- R8: A symbol produced in the same cycle as a start pulse is not counted.
- R9: When a boundary latches an offset that differs from the lane's previous latched value (after the limit of R3), that lane's count becomes zero, whether or not a window is running.
- R10: A count stops at its all-ones value and never wraps.
- R11: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, five per pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_i | input | 2*NUM_CH | Two new bits per lane, lane c in bits [2c+1:2c] |
| offset_i | input | 4*NUM_CH | Window offset per lane, lane c in bits [4c+3:4c] |
| scan_start_i | input | 1 | One-cycle pulse that starts a measurement window |
| scan_len_i | input | WIN_W | Window length in symbols, sampled with the start pulse |
| word_o | output | 10*NUM_CH | Aligned symbols of all lanes |
| word_valid_o | output | 1 | One-cycle pulse when a new word is presented |
| tok_count_o | output | CNT_W*NUM_CH | Control-token count per lane |
| scan_done_o | output | 1 | Window finished; counts are final |

## Verification
A start pulse can land in the same fast cycle in which a new symbol is scored. If the window logic does not give the start priority, the old count survives, or the new window counts one symbol too many. The bench provokes this by raising the start pulse in the cycle that follows a pixel boundary. It then compares each lane's count against a reference that leaves out that symbol and scores exactly the next L. A second overlap comes from offset writes made on a boundary cycle and one cycle later, in the middle of a window. These are judged by whether the count drops to zero at the correct boundary.

// File: rtl/wordalign_pkg.sv
package wordalign_pkg;
    localparam int SYM_W  = 10;
    localparam int PAIR_W = 2;
    localparam int PAIRS  = SYM_W / PAIR_W;
    localparam int HIST_W = 2 * SYM_W;
    localparam int OFF_W  = $clog2(SYM_W);
    localparam int N_TOK  = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t CTRL_TOK [N_TOK] = '{10'h354, 10'h0AB, 10'h154, 10'h2AB};

    function automatic logic is_ctrl_tok(input sym_t s);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_TOK; i++) begin
            if (s == CTRL_TOK[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic [OFF_W-1:0] clamp_off(input logic [OFF_W-1:0] o);
        return (o > OFF_W'(SYM_W-1)) ? OFF_W'(SYM_W-1) : o;
    endfunction
endpackage

// File: rtl/wa_phase.sv
module wa_phase
    import wordalign_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic eval_o,
    output logic valid_o
);
    localparam int PH_W = $clog2(PAIRS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAIRS-1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            primed;
        logic            vld;
    } phase_st_t;

    phase_st_t s_q, s_d;

    assign load_o  = (s_q.ph == PH_LAST);
    assign eval_o  = (s_q.ph == '0) && s_q.primed;
    assign valid_o = s_q.vld;

    always_comb begin
        s_d     = s_q;
        s_d.ph  = (s_q.ph == PH_LAST) ? '0 : s_q.ph + 1'b1;
        if (s_q.ph == PH_LAST) s_d.primed = 1'b1;
        s_d.vld = eval_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: a word is scored in the cycle right after each boundary
    assert_eval_after_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> eval_o);
    // R4: valid is a single-cycle pulse
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/wa_scan.sv
module wa_scan #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIN_W-1:0] len_i,
    input  logic             eval_i,
    output logic             cnt_en_o,
    output logic             clr_o,
    output logic             done_o
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [WIN_W-1:0] left;
    } scan_st_t;

    scan_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.left = (len_i == '0) ? ONE : len_i;
        end else if (s_q.busy && eval_i) begin
            s_d.left = s_q.left - 1'b1;
            if (s_q.left == ONE) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    assign cnt_en_o = s_q.busy && eval_i && !start_i;
    assign clr_o    = start_i;
    assign done_o   = s_q.done;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: done persists until the next start
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    // R7: a start always opens a window and drops done
    assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (s_q.busy && !done_o));
    // R7: running and finished never overlap
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.busy && s_q.done));
endmodule

// File: rtl/wa_channel.sv
module wa_channel
    import wordalign_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] pair_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic              load_i,
    input  logic              eval_i,
    input  logic              cnt_en_i,
    input  logic              clr_i,
    output sym_t              sym_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int GATH_W = SYM_W - PAIR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [GATH_W-1:0] gath;
        logic [HIST_W-1:0] hist;
        logic [OFF_W-1:0]  off;
        sym_t              sym;
        logic [CNT_W-1:0]  cnt;
    } chan_st_t;

    chan_st_t         s_q, s_d;
    logic [OFF_W-1:0] off_new;
    logic             off_chg;
    sym_t             word_new;
    sym_t             sel;

    always_comb begin
        off_new  = clamp_off(offset_i);
        off_chg  = load_i && (off_new != s_q.off);
        word_new = {pair_i, s_q.gath};
        sel      = sym_t'(s_q.hist >> s_q.off);

        s_d      = s_q;
        s_d.gath = {pair_i, s_q.gath[GATH_W-1:PAIR_W]};
        if (load_i) begin
            s_d.hist = {word_new, s_q.hist[HIST_W-1:SYM_W]};
            s_d.off  = off_new;
        end
        if (eval_i) s_d.sym = sel;
        if (clr_i || off_chg) begin
            s_d.cnt = '0;
        end else if (cnt_en_i && is_ctrl_tok(sel) && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign sym_o   = s_q.sym;
    assign count_o = s_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: the latched offset never leaves 0..9
    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.off <= OFF_W'(SYM_W-1));
    // R9: whenever the latched offset moves, the count is zero
    assert_offset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.off) |-> (count_o == '0));
    // R7: a start empties the count
    assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));
    // R10: a full count never wraps into a small nonzero value
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> ((count_o == CNT_MAX) || (count_o == '0)));
    // R4: the symbol only moves on a scoring cycle
    assert_sym_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(sym_o));
endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner
    import wordalign_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*PAIR_W-1:0]  pair_i,
    input  logic [NUM_CH*OFF_W-1:0]   offset_i,
    input  logic                      scan_start_i,
    input  logic [WIN_W-1:0]          scan_len_i,
    output logic [NUM_CH*SYM_W-1:0]   word_o,
    output logic                      word_valid_o,
    output logic [NUM_CH*CNT_W-1:0]   tok_count_o,
    output logic                      scan_done_o
);
    logic load;
    logic eval;
    logic cnt_en;
    logic clr;

    wa_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_o  (load),
        .eval_o  (eval),
        .valid_o (word_valid_o)
    );

    wa_scan #(.WIN_W(WIN_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (scan_start_i),
        .len_i    (scan_len_i),
        .eval_i   (eval),
        .cnt_en_o (cnt_en),
        .clr_o    (clr),
        .done_o   (scan_done_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wa_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pair_i   (pair_i[g*PAIR_W +: PAIR_W]),
            .offset_i (offset_i[g*OFF_W +: OFF_W]),
            .load_i   (load),
            .eval_i   (eval),
            .cnt_en_i (cnt_en),
            .clr_i    (clr),
            .sym_o    (word_o[g*SYM_W +: SYM_W]),
            .count_o  (tok_count_o[g*CNT_W +: CNT_W])
        );
    end

    // R4: the wide word moves only together with the valid pulse
    assert_word_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> word_valid_o);
endmodule

// File: tb/serial_word_aligner_bench.sv
module serial_word_aligner_bench;
    localparam int NCH  = 3;
    localparam int SW   = 10;
    localparam int OW   = 4;
    localparam int CW   = 4;
    localparam int WW   = 8;
    localparam int CMAX = (1 << CW) - 1;
    localparam int SKEW [NCH] = '{3, 7, 0};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH*2-1:0]    pair = '0;
    logic [NCH*OW-1:0]   offs = '0;
    logic                start = 1'b0;
    logic [WW-1:0]       len = '0;
    logic [NCH*SW-1:0]   word;
    logic                wvalid;
    logic [NCH*CW-1:0]   counts;
    logic                done;

    serial_word_aligner #(.NUM_CH(NCH), .CNT_W(CW), .WIN_W(WW)) u_serial_word_aligner (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_i       (pair),
        .offset_i     (offs),
        .scan_start_i (start),
        .scan_len_i   (len),
        .word_o       (word),
        .word_valid_o (wvalid),
        .tok_count_o  (counts),
        .scan_done_o  (done)
    );

    always #5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int c = 0;
    string tag = "R11";

    int         drv_off [NCH] = '{0, 0, 0};
    int         m_klat  [NCH] = '{0, 0, 0};
    int         m_cnt   [NCH] = '{0, 0, 0};
    logic [9:0] exp_sym [NCH] = '{10'h0, 10'h0, 10'h0};
    bit         exp_valid = 1'b0;
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         m_left = 0;

    function automatic logic [9:0] tok(int i);
        case (i % 4)
            0:       return 10'h354;
            1:       return 10'h0AB;
            2:       return 10'h154;
            default: return 10'h2AB;
        endcase
    endfunction

    function automatic bit is_tok(logic [9:0] s);
        return (s == 10'h354) || (s == 10'h0AB) || (s == 10'h154) || (s == 10'h2AB);
    endfunction

    function automatic logic [9:0] src_sym(int ch, int idx);
        if (idx % 3 == 0) return tok(idx / 3 + ch);
        return 10'((idx * 73 + ch * 211 + 5) % 1024);
    endfunction

    function automatic bit sbit(int ch, int n);
        int u;
        logic [9:0] s;
        if (n < 0) return 1'b0;
        u = n + 10 - SKEW[ch];
        s = src_sym(ch, u / 10);
        return s[u % 10];
    endfunction

    task automatic chk(bit ok, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d actual %0h expected %0h", what, tag, c, act, expv);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // reference for one rising edge numbered c
    task automatic model();
        int  ph;
        bit  ev;
        int  kc;
        ph = c % 5;
        ev = (ph == 0) && (c >= 5);
        exp_valid = ev;
        if (ev) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int i = 0; i < SW; i++)
                    exp_sym[ch][i] = sbit(ch, 2 * c - 20 + m_klat[ch] + i);
            end
        end
        if (start) begin
            m_busy = 1'b1;
            m_done = 1'b0;
            m_left = (len == 0) ? 1 : int'(len);
            for (int ch = 0; ch < NCH; ch++) m_cnt[ch] = 0;
        end else if (ev && m_busy) begin
            for (int ch = 0; ch < NCH; ch++)
                if (is_tok(exp_sym[ch]) && m_cnt[ch] < CMAX) m_cnt[ch]++;
            m_left--;
            if (m_left == 0) begin
                m_busy = 1'b0;
                m_done = 1'b1;
            end
        end
        if (ph == 4) begin
            for (int ch = 0; ch < NCH; ch++) begin
                kc = (drv_off[ch] > 9) ? 9 : drv_off[ch];
                if (kc != m_klat[ch]) begin
                    m_klat[ch] = kc;
                    m_cnt[ch]  = 0;
                end
            end
        end
    endtask

    task automatic compare();
        chk(wvalid === exp_valid, "R4 valid pulse", int'(wvalid), int'(exp_valid));
        for (int ch = 0; ch < NCH; ch++)
            chk(word[ch*SW +: SW] === exp_sym[ch], "R1/R2/R3/R5 symbol",
                int'(word[ch*SW +: SW]), int'(exp_sym[ch]));
        chk(done === m_done, "R7 done flag", int'(done), int'(m_done));
        for (int ch = 0; ch < NCH; ch++)
            chk(counts[ch*CW +: CW] === CW'(m_cnt[ch]), "R6/R8/R9/R10 count",
                int'(counts[ch*CW +: CW]), m_cnt[ch]);
    endtask

    task automatic cyc();
        for (int ch = 0; ch < NCH; ch++) begin
            pair[2*ch]       = sbit(ch, 2 * c);
            pair[2*ch+1]     = sbit(ch, 2 * c + 1);
            offs[OW*ch +: OW] = OW'(drv_off[ch]);
        end
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
        c++;
        start = 1'b0;
    endtask

    task automatic window(int l);
        start = 1'b1;
        len   = WW'(l);
        cyc();
        for (int i = 0; i < 400 && !m_done; i++) cyc();
        repeat (3) cyc();
    endtask

    task automatic set_all(int k);
        for (int ch = 0; ch < NCH; ch++) drv_off[ch] = k;
    endtask

    initial begin
        // R11: outputs during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word === '0, "R11 word in reset", int'(word), 0);
        chk(wvalid === 1'b0, "R11 valid in reset", int'(wvalid), 0);
        chk(counts === '0, "R11 counts in reset", int'(counts), 0);
        chk(done === 1'b0, "R11 done in reset", int'(done), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R6 R7: sweep of all offsets on every lane
        tag = "R1/R2/R3/R6/R7 offset sweep";
        repeat (7) cyc();
        for (int k = 0; k < 10; k++) begin
            set_all(k);
            repeat (6 + k) cyc();
            window(12);
        end

        // R10: aligned lanes over a long window saturate
        tag = "R10 saturation";
        for (int ch = 0; ch < NCH; ch++) drv_off[ch] = SKEW[ch];
        repeat (8) cyc();
        window(70);

        // R8: start in the scoring cycle
        tag = "R8 start on scoring cycle";
        while (c % 5 != 0) cyc();
        window(6);
        while (c % 5 != 0) cyc();
        window(9);

        // R7: zero length acts as one
        tag = "R7 zero length";
        window(0);

        // R9 R5 R3: offset moves inside and outside a window
        tag = "R9/R5/R3 offset change";
        start = 1'b1;
        len   = WW'(40);
        cyc();
        repeat (30) cyc();
        while (c % 5 != 4) cyc();
        drv_off[1] = 2;          // written on a boundary cycle
        cyc();
        repeat (12) cyc();
        while (c % 5 != 0) cyc();
        drv_off[0] = 12;         // just after a boundary, above the limit
        cyc();
        repeat (20) cyc();
        drv_off[0] = 9;          // same after the limit: no clear
        repeat (20) cyc();
        for (int i = 0; i < 300 && !m_done; i++) cyc();
        drv_off[2] = 5;          // outside any window
        repeat (12) cyc();

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog [%s] run did not finish", tag);
        summary();
        $finish;
    end
endmodule